// File: doc/BRIEF.md
# Address Generation and Increment Unit

This block keeps the address-side registers of an 8-bit processor: a 16-bit program counter (two bytes), a 16-bit data pointer (two bytes), a stack pointer byte and a temporary byte. Each clock cycle a 3-bit source code decides which register pair drives the 16-bit internal address. For stack, zero-page and top-page accesses the high address byte is replaced by a fixed constant.

A 16-bit incrementer takes its operand straight from register outputs. A 3-bit increment code chooses both the operand and the register that receives the result. Registers load from an 8-bit write bus through a 3-bit write code. The high data-pointer byte also loads from the external data byte under its own strobe. Any register can be read back on an 8-bit read-back output.

Every pin is a per-cycle control or a combinational view of register state. Nothing is queued, so there is no valid/ready handshake and no back-pressure: each control word is consumed at the clock edge where it is present. The external tri-state buffer is driven by an output-enable that follows the bus-enable input.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, all six registers read back as 0 and the program-counter source drives address 0x0000.
- R2: Address source code `asrc` selects the address as follows: 0 gives {DPH,DPL}; 1 gives {PCH,PCL}; 2 gives {0x01,SP}; 3 gives {0x00,DPL}; 4 gives {0xFF,DPL}; 5 gives {DPH,T}. Codes 6 and 7 drive 0x0000.
- R3: Write code `wr_sel` loads `wbus` at the clock edge into 1=PCL, 2=PCH, 3=DPL, 4=DPH, 5=SP or 6=T. Code 0 and code 7 load nothing. Read code `rd_sel` uses the same numbering and shows the register on `rd_byte` in the same cycle; codes 0 and 7 give 0x00.
- R4: `dph_ld` loads `dbus` into DPH. If `wr_sel` targets DPH in the same cycle, `dph_ld` wins.
- R5: Increment code 1 writes PC+1 into PC. The high byte gains a carry only when PCL is 0xFF, and 0xFFFF wraps to 0x0000.
- R6: Increment code 2 writes the 16-bit value DP+1 into PC and leaves DP unchanged. The carry crosses pages.
- R7: Increment code 3 writes DPL+1 into DPL only. 0xFF wraps to 0x00 and DPH is unchanged.
- R8: Increment code 4 increments SP and code 5 increments T, each wrapping modulo 256. Codes 6 and 7 change nothing.
- R9: With increment code 0, write code 0 and `dph_ld` low, every register holds its value.
- R10: When `wr_sel` and the increment code target the same byte in one cycle, the write-bus value is stored in that byte. Any other byte written by the incrementer still takes its incremented value.
- R11: `addr_oe` equals `bus_en` in the same cycle, and `addr_out` is unaffected by `bus_en`.
- R12: A three-cycle absolute jump works as follows. PC addresses the low target byte, which is loaded into DPL while PC increments. PC then addresses the high target byte, which is loaded into DPH while PC increments. In the third cycle DP drives the address and increment code 2 is applied, so PC holds target+1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| asrc | input | 3 | Address source code |
| inc_sel | input | 3 | Increment operation and destination code |
| wr_sel | input | 3 | Write-bus destination code |
| wbus | input | 8 | Write bus byte |
| dbus | input | 8 | External data byte for DPH |
| dph_ld | input | 1 | Load DPH from dbus |
| rd_sel | input | 3 | Read-back register code |
| bus_en | input | 1 | External address bus enable |
| addr_out | output | 16 | Internal address |
| addr_oe | output | 1 | Output enable for the external address buffer |
| rd_byte | output | 8 | Read-back register byte |

## Verification
`addr_out`, `rd_byte` and `addr_oe` are combinational from register state and the select codes, so they are due as soon as the selects settle. Loads and increments appear one clock after the edge that samples them. The bench changes its inputs 1 ns after a rising edge. It checks combinational views 1 ns after changing a select, and checks register effects right after the following rising edge. In the jump sequence, the address is checked in the cycle DP drives it, and the new PC is checked on the edge after that.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    ASRC_DP  = 3'd0,
    ASRC_PC  = 3'd1,
    ASRC_STK = 3'd2,
    ASRC_ZPG = 3'd3,
    ASRC_TOP = 3'd4,
    ASRC_HT  = 3'd5
  } asrc_e;

  typedef enum logic [2:0] {
    INC_NONE  = 3'd0,
    INC_PC    = 3'd1,
    INC_DP2PC = 3'd2,
    INC_DPL   = 3'd3,
    INC_SP    = 3'd4,
    INC_T     = 3'd5
  } inc_e;

  // register slot index; write/read code of slot i is i+1
  localparam int RI_PCL = 0;
  localparam int RI_PCH = 1;
  localparam int RI_DPL = 2;
  localparam int RI_DPH = 3;
  localparam int RI_SP  = 4;
  localparam int RI_T   = 5;
  localparam int NREG   = 6;

endpackage

// File: rtl/agu_inc16.sv
// Two-byte incrementer: carry into the high byte comes from an all-ones
// detect on the low byte rather than a ripple through it.
module agu_inc16 #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] op_hi,
  input  logic [BW-1:0] op_lo,
  output logic [BW-1:0] res_hi,
  output logic [BW-1:0] res_lo
);
  logic lo_full;

  assign lo_full = &op_lo;
  assign res_lo  = op_lo + BW'(1);
  assign res_hi  = op_hi + {{(BW-1){1'b0}}, lo_full};
endmodule

// File: rtl/agu_regs.sv
import agu_pkg::*;

module agu_regs #(
  parameter int BW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 wr_sel,
  input  logic [BW-1:0]              wbus,
  input  logic                       dph_ld,
  input  logic [BW-1:0]              dbus,
  input  logic [NREG-1:0]            inc_we,
  input  logic [NREG-1:0][BW-1:0]    inc_val,
  output logic [NREG-1:0][BW-1:0]    q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_hit;
    assign wr_hit = (wr_sel == 3'(g + 1));

    if (g == RI_DPH) begin : g_ext
      always_ff @(posedge clk) begin
        if (!rst_n)           q[g] <= '0;
        else if (dph_ld)      q[g] <= dbus;
        else if (wr_hit)      q[g] <= wbus;
      end
    end else begin : g_int
      always_ff @(posedge clk) begin
        if (!rst_n)           q[g] <= '0;
        else if (wr_hit)      q[g] <= wbus;
        else if (inc_we[g])   q[g] <= inc_val[g];
      end
    end
  end

  logic unused_dph;
  assign unused_dph = inc_we[RI_DPH] ^ (|inc_val[RI_DPH]);
endmodule

// File: rtl/agu_src_mux.sv
import agu_pkg::*;

module agu_src_mux #(
  parameter int BW       = 8,
  parameter int STK_PAGE = 1
) (
  input  logic [2:0]              asrc,
  input  logic [2:0]              rd_sel,
  input  logic [NREG-1:0][BW-1:0] q,
  output logic [2*BW-1:0]         addr,
  output logic [BW-1:0]           rd_byte
);
  localparam logic [BW-1:0] PG_STK = BW'(STK_PAGE);
  localparam logic [BW-1:0] PG_ZER = '0;
  localparam logic [BW-1:0] PG_TOP = '1;

  always_comb begin
    case (asrc)
      ASRC_DP:  addr = {q[RI_DPH], q[RI_DPL]};
      ASRC_PC:  addr = {q[RI_PCH], q[RI_PCL]};
      ASRC_STK: addr = {PG_STK,    q[RI_SP]};
      ASRC_ZPG: addr = {PG_ZER,    q[RI_DPL]};
      ASRC_TOP: addr = {PG_TOP,    q[RI_DPL]};
      ASRC_HT:  addr = {q[RI_DPH], q[RI_T]};
      default:  addr = '0;
    endcase
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel == 3'(i + 1)) rd_byte = q[i];
  end
endmodule

// File: rtl/addr_gen_unit.sv
import agu_pkg::*;

module addr_gen_unit #(
  parameter int BW       = 8,
  parameter int STK_PAGE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      asrc,
  input  logic [2:0]      inc_sel,
  input  logic [2:0]      wr_sel,
  input  logic [7:0]      wbus,
  input  logic [7:0]      dbus,
  input  logic            dph_ld,
  input  logic [2:0]      rd_sel,
  input  logic            bus_en,
  output logic [15:0]     addr_out,
  output logic            addr_oe,
  output logic [7:0]      rd_byte
);
  localparam int AW = 2 * BW;

  logic [NREG-1:0][BW-1:0] q;
  logic [NREG-1:0][BW-1:0] inc_val;
  logic [NREG-1:0]         inc_we;
  logic [BW-1:0]           op_hi, op_lo, res_hi, res_lo;
  logic [AW-1:0]           addr_int;
  logic [BW-1:0]           rd_int;

  // operand comes from register outputs, never from the address bus
  always_comb begin
    op_hi  = '0;
    op_lo  = '0;
    inc_we = '0;
    case (inc_sel)
      INC_PC: begin
        op_hi = q[RI_PCH]; op_lo = q[RI_PCL];
        inc_we[RI_PCH] = 1'b1; inc_we[RI_PCL] = 1'b1;
      end
      INC_DP2PC: begin
        op_hi = q[RI_DPH]; op_lo = q[RI_DPL];
        inc_we[RI_PCH] = 1'b1; inc_we[RI_PCL] = 1'b1;
      end
      INC_DPL: begin
        op_lo = q[RI_DPL]; inc_we[RI_DPL] = 1'b1;
      end
      INC_SP: begin
        op_lo = q[RI_SP];  inc_we[RI_SP] = 1'b1;
      end
      INC_T: begin
        op_lo = q[RI_T];   inc_we[RI_T] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    inc_val         = '0;
    inc_val[RI_PCL] = res_lo;
    inc_val[RI_PCH] = res_hi;
    inc_val[RI_DPL] = res_lo;
    inc_val[RI_SP]  = res_lo;
    inc_val[RI_T]   = res_lo;
  end

  agu_inc16 #(.BW(BW)) u_inc (
    .op_hi (op_hi),
    .op_lo (op_lo),
    .res_hi(res_hi),
    .res_lo(res_lo)
  );

  agu_regs #(.BW(BW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (wr_sel),
    .wbus   (BW'(wbus)),
    .dph_ld (dph_ld),
    .dbus   (BW'(dbus)),
    .inc_we (inc_we),
    .inc_val(inc_val),
    .q      (q)
  );

  agu_src_mux #(.BW(BW), .STK_PAGE(STK_PAGE)) u_mux (
    .asrc   (asrc),
    .rd_sel (rd_sel),
    .q      (q),
    .addr   (addr_int),
    .rd_byte(rd_int)
  );

  assign addr_out = 16'(addr_int);
  assign rd_byte  = 8'(rd_int);
  assign addr_oe  = bus_en;
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  asrc,
  input logic [2:0]  inc_sel,
  input logic [2:0]  wr_sel,
  input logic        dph_ld,
  input logic [15:0] addr_out
);
  logic quiet;
  assign quiet = (inc_sel == 3'd0) && (wr_sel == 3'd0) && !dph_ld;

  // R2
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asrc == 3'd2) |-> (addr_out[15:8] == 8'h01));
  // R2
  zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asrc == 3'd3) |-> (addr_out[15:8] == 8'h00));
  // R2
  top_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asrc == 3'd4) |-> (addr_out[15:8] == 8'hFF));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (!$stable(asrc) || $stable(addr_out)));
  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asrc == 3'd1 && inc_sel == 3'd1 && wr_sel == 3'd0) |=>
      (asrc != 3'd1 || addr_out == 16'($past(addr_out) + 16'd1)));
  // R7
  dpl_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asrc == 3'd0 && inc_sel == 3'd3 && wr_sel == 3'd0 && !dph_ld) |=>
      (asrc != 3'd0 ||
       addr_out == {$past(addr_out[15:8]), 8'($past(addr_out[7:0]) + 8'd1)}));
endmodule

bind addr_gen_unit agu_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .asrc    (asrc),
  .inc_sel (inc_sel),
  .wr_sel  (wr_sel),
  .dph_ld  (dph_ld),
  .addr_out(addr_out)
);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  asrc = 0, inc_sel = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0]  wbus = 0, dbus = 0;
  logic        dph_ld = 0, bus_en = 1;
  logic [15:0] addr_out;
  logic        addr_oe;
  logic [7:0]  rd_byte;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .asrc(asrc), .inc_sel(inc_sel),
    .wr_sel(wr_sel), .wbus(wbus), .dbus(dbus), .dph_ld(dph_ld),
    .rd_sel(rd_sel), .bus_en(bus_en), .addr_out(addr_out),
    .addr_oe(addr_oe), .rd_byte(rd_byte)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic idle;
    inc_sel = 0; wr_sel = 0; dph_ld = 0;
  endtask

  task automatic ld(input logic [2:0] sel, input logic [7:0] v);
    wr_sel = sel; wbus = v; tick; idle;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] v);
    rd_sel = sel; #1; v = rd_byte;
  endtask

  task automatic addr_at(input logic [2:0] s, output logic [15:0] v);
    asrc = s; #1; v = addr_out;
  endtask

  task automatic set_pc(input logic [15:0] v);
    ld(3'd1, v[7:0]); ld(3'd2, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] v; logic [15:0] a;
    for (int i = 1; i <= 6; i++) begin
      rd(3'(i), v); chk("R1 reset reg", {8'h0, v}, 16'h0);
    end
    addr_at(3'd1, a); chk("R1 reset addr", a, 16'h0000);
  endtask

  task automatic t_load_read;
    logic [7:0] v;
    for (int i = 1; i <= 6; i++) ld(3'(i), 8'(8'h10 * i + i));
    for (int i = 1; i <= 6; i++) begin
      rd(3'(i), v); chk("R3 read back", {8'h0, v}, {8'h0, 8'(8'h10 * i + i)});
    end
    rd(3'd0, v); chk("R3 rd code 0", {8'h0, v}, 16'h0);
    ld(3'd7, 8'hEE);
    rd(3'd7, v); chk("R3 rd code 7", {8'h0, v}, 16'h0);
    rd(3'd6, v); chk("R3 wr code 7 no effect", {8'h0, v}, 16'h0066);
  endtask

  task automatic t_sources;
    logic [15:0] a;
    set_pc(16'h1234); ld(3'd3, 8'hCD); ld(3'd4, 8'hAB);
    ld(3'd5, 8'h5E); ld(3'd6, 8'h77);
    addr_at(3'd0, a); chk("R2 dp", a, 16'hABCD);
    addr_at(3'd1, a); chk("R2 pc", a, 16'h1234);
    addr_at(3'd2, a); chk("R2 stack", a, 16'h015E);
    addr_at(3'd3, a); chk("R2 zero page", a, 16'h00CD);
    addr_at(3'd4, a); chk("R2 top page", a, 16'hFFCD);
    addr_at(3'd5, a); chk("R2 dph/t", a, 16'hAB77);
    addr_at(3'd6, a); chk("R2 code 6", a, 16'h0000);
  endtask

  task automatic t_dph;
    logic [7:0] v;
    dph_ld = 1; dbus = 8'h3C; wr_sel = 3'd4; wbus = 8'h99; tick; idle;
    rd(3'd4, v); chk("R4 dph_ld wins", {8'h0, v}, 16'h003C);
    dph_ld = 1; dbus = 8'hA5; tick; idle;
    rd(3'd4, v); chk("R4 dph from dbus", {8'h0, v}, 16'h00A5);
  endtask

  task automatic t_pc_inc;
    logic [15:0] a;
    set_pc(16'h12FF); asrc = 3'd1; inc_sel = 3'd1; tick; idle;
    addr_at(3'd1, a); chk("R5 carry from PCL FF", a, 16'h1300);
    inc_sel = 3'd1; tick; idle;
    addr_at(3'd1, a); chk("R5 no carry", a, 16'h1301);
    set_pc(16'hFFFF); inc_sel = 3'd1; tick; idle;
    addr_at(3'd1, a); chk("R5 full wrap", a, 16'h0000);
  endtask

  task automatic t_dpl;
    logic [15:0] a;
    ld(3'd3, 8'hFF); ld(3'd4, 8'h40);
    asrc = 3'd0; inc_sel = 3'd3; tick; idle;
    addr_at(3'd0, a); chk("R7 dpl wraps in page", a, 16'h4000);
  endtask

  task automatic t_sp_t;
    logic [7:0] v; logic [15:0] a;
    ld(3'd5, 8'hFF); ld(3'd6, 8'h7F);
    inc_sel = 3'd4; tick; idle;
    rd(3'd5, v); chk("R8 sp wrap", {8'h0, v}, 16'h0000);
    inc_sel = 3'd5; tick; idle;
    rd(3'd6, v); chk("R8 t inc", {8'h0, v}, 16'h0080);
    set_pc(16'h2222);
    inc_sel = 3'd6; tick; inc_sel = 3'd7; tick; idle;
    addr_at(3'd1, a); chk("R8 code 6/7 pc", a, 16'h2222);
    rd(3'd6, v); chk("R8 code 6/7 t", {8'h0, v}, 16'h0080);
  endtask

  task automatic t_hold;
    logic [15:0] a;
    set_pc(16'h5A5A);
    repeat (4) tick;
    addr_at(3'd1, a); chk("R9 hold", a, 16'h5A5A);
  endtask

  task automatic t_prio;
    logic [15:0] a;
    set_pc(16'h00FF);
    inc_sel = 3'd1; wr_sel = 3'd1; wbus = 8'h55; tick; idle;
    addr_at(3'd1, a); chk("R10 write beats inc", a, 16'h0155);
  endtask

  task automatic t_oe;
    logic [15:0] a;
    set_pc(16'hBEEF); asrc = 3'd1;
    bus_en = 0; #1; a = addr_out;
    chk("R11 oe low", {15'h0, addr_oe}, 16'h0);
    chk("R11 addr kept", a, 16'hBEEF);
    bus_en = 1; #1;
    chk("R11 oe high", {15'h0, addr_oe}, 16'h1);
  endtask

  task automatic t_jump;
    logic [15:0] a;
    set_pc(16'h0200);
    asrc = 3'd1; inc_sel = 3'd1; wr_sel = 3'd3; wbus = 8'h34; tick; idle;
    asrc = 3'd1; inc_sel = 3'd1; dph_ld = 1; dbus = 8'h12; tick; idle;
    addr_at(3'd1, a); chk("R12 pc after operands", a, 16'h0202);
    addr_at(3'd0, a); chk("R12 dp drives target", a, 16'h1234);
    inc_sel = 3'd2; tick; idle;
    addr_at(3'd1, a); chk("R6 R12 pc = target+1", a, 16'h1235);
    addr_at(3'd0, a); chk("R6 dp unchanged", a, 16'h1234);
    ld(3'd3, 8'hFF); ld(3'd4, 8'h12);
    inc_sel = 3'd2; tick; idle;
    addr_at(3'd1, a); chk("R6 crosses page", a, 16'h1300);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick;
    rst_n = 1;
    t_reset;
    t_load_read;
    t_sources;
    t_dph;
    t_pc_inc;
    t_dpl;
    t_sp_t;
    t_hold;
    t_prio;
    t_oe;
    t_jump;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule